// File: doc/BRIEF.md
# Round-Robin Serial ADC Poller

This block is a small SPI master that reads a set of external serial analog-to-digital converters one after another, in a fixed circular order, and keeps the newest sample of every channel in a result register that can be read at any time. All converters share one serial data input. The master selects exactly one of them at a time: it drives a select strobe and a channel code, generates the serial clock, shifts in the sample most significant bit first, and stores it.

A two-bit mode input chooses how the converters are wired. In quad mode one four-channel device with 12-bit samples is attached, and the low two bits of the channel code go straight to its two select inputs. In the two decoder modes, eight single-channel converters sit behind an external 3-to-8 decoder, which turns the channel code and the active-low strobe into one select line per converter. These modes use 15-bit or 16-bit samples. The serial clock is the block clock divided by an even number that can be set, and an enable input starts and stops the polling loop.

The control path is a five-state machine. `ST_IDLE` waits for enable. `ST_SETUP` holds the select for half a serial clock period before the first rising edge. `ST_HIGH` and `ST_LOW` are the two halves of each serial clock period. `ST_GAP` keeps the converters deselected for one full period. The transitions are: start (IDLE→SETUP, which latches the mode and divisor), first edge (SETUP→HIGH), next bit (HIGH→LOW and LOW→HIGH), last bit (HIGH→GAP, where the sample is stored), next channel (GAP→SETUP while enabled) and stop (GAP→IDLE when disabled).

Top module: `rr_adc_sampler`

## Requirements
- R1: While reset is asserted, and directly after it, `sel_n` is 1, `sclk` is 0, every bit of `valid_vec` is 0 and every result reads 0.
- R2: While `enable` is low and no frame is in progress, `sel_n` stays 1 and `sclk` stays 0.
- R3: After a start from idle, frames visit channels 0, 1, 2, … in order and wrap to 0 after the last active channel. Quad mode has 4 active channels. The decoder modes have 8 (at most NCH).
- R4: Each frame has exactly as many rising `sclk` edges as the sample width: 12 in mode 2'b00, 15 in mode 2'b01, 16 in modes 2'b10 and 2'b11.
- R5: `miso` is sampled on each rising `sclk` edge. The first bit taken becomes the MSB of the sample. The sample is right-aligned and zero-extended in `rd_data`.
- R6: Every high phase and every low phase of `sclk` inside a frame, including the setup phase before the first rising edge, lasts H clock cycles. H is `sclk_half`, or 1 when `sclk_half` is 0. The serial clock period is therefore the even value 2·H.
- R7: `cs_code` does not change while `sel_n` is low. Between two back-to-back frames, `sel_n` is high for at least 2·H cycles, which is exactly 2·H.
- R8: In quad mode, `cs_code` carries the channel number in bits [1:0] and its upper bits are 0. In decoder modes, `cs_code` is the binary channel number.
- R9: Storing a sample sets that channel's `valid_vec` bit, and the bit then stays set. Channels beyond the active count are never written.
- R10: Lowering `enable` lets the current frame finish and store its sample, then the block goes idle. Changes to `mode` and `sclk_half` take effect only at the next start from idle.
- R11: `sclk` is high only while `sel_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the polling loop while high |
| mode | input | 2 | 00 quad/12-bit, 01 decoder/15-bit, 10 and 11 decoder/16-bit |
| sclk_half | input | DIV_W | Half serial clock period in clock cycles (0 acts as 1) |
| miso | input | 1 | Shared serial data from all converters |
| sclk | output | 1 | Serial clock, idle low |
| sel_n | output | 1 | Active-low converter select strobe |
| cs_code | output | $clog2(NCH) | Channel code for direct select lines or the external decoder |
| rd_sel | input | $clog2(NCH) | Channel whose result is read |
| rd_data | output | SW | Stored sample of the channel chosen by `rd_sel` |
| valid_vec | output | NCH | One bit per channel, set once a sample has been stored |

## Verification
On every cycle, the assertions check the framing rules. The serial clock toggles only under select, the channel code holds during a frame, the deselect gap between back-to-back frames is long enough, each frame has the right number of rising edges for the latched mode, quad-mode codes have their upper bits clear, and valid flags never drop. Other behaviour shows only in the bench scenarios. These cover the channel order after each start, the phase lengths for each divisor, the captured values from a converter model driving distinct per-channel patterns, the effect of a mode or divisor change in mid-run, and the finish-then-stop behaviour when enable drops.

// File: rtl/rr_adc_pkg.sv
package rr_adc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_GAP   = 3'd4
    } fsm_t;

    localparam logic [1:0] MD_QUAD12 = 2'b00;
    localparam logic [1:0] MD_DEC15  = 2'b01;
    localparam logic [1:0] MD_DEC16  = 2'b10;

    // bits per sample for a wiring mode
    function automatic int unsigned mode_width(input logic [1:0] m);
        unique case (m)
            MD_QUAD12: return 12;
            MD_DEC15:  return 15;
            default:   return 16;
        endcase
    endfunction

    // channels visited in a wiring mode, limited by the instance size
    function automatic int unsigned mode_chans(input logic [1:0] m, input int unsigned nmax);
        int unsigned n;
        n = (m == MD_QUAD12) ? 4 : 8;
        return (n < nmax) ? n : nmax;
    endfunction

endpackage

// File: rtl/rr_adc_sclk_timer.sv
module rr_adc_sclk_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_m1,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || cnt_q == '0) begin
            cnt_q <= half_m1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/rr_adc_frame_ctrl.sv
module rr_adc_frame_ctrl
    import rr_adc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int SW    = 16,
    parameter int DIV_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [1:0]               mode_in,
    input  logic [DIV_W-1:0]         half_in,
    input  logic                     tick,
    input  logic                     miso,
    output logic                     busy,
    output logic [DIV_W-1:0]         half_m1,
    output logic                     sclk,
    output logic                     sel_n,
    output logic [$clog2(NCH)-1:0]   cs_code,
    output logic                     wr_en,
    output logic [$clog2(NCH)-1:0]   wr_ch,
    output logic [SW-1:0]            wr_data,
    output logic [1:0]               mode_q,
    output logic [DIV_W-1:0]         half_q
);

    localparam int CHW = $clog2(NCH);
    localparam int BCW = $clog2(SW + 1);

    fsm_t state, nxt;

    logic [CHW-1:0] ch_q;
    logic [BCW-1:0] bits_q;
    logic [SW-1:0]  shreg_q;
    logic           gap_hold_q;

    logic [BCW-1:0]   width_now;
    logic [CHW-1:0]   last_ch;
    logic [DIV_W-1:0] half_live;
    logic             last_bit;

    assign width_now = BCW'(mode_width(mode_q));
    assign last_ch   = CHW'(mode_chans(mode_q, NCH) - 1);
    assign half_live = (half_in == '0) ? '0 : half_in - 1'b1;
    assign last_bit  = (bits_q == width_now);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (enable) nxt = ST_SETUP;
            ST_SETUP: if (tick) nxt = ST_HIGH;
            ST_HIGH:  if (tick) nxt = last_bit ? ST_GAP : ST_LOW;
            ST_LOW:   if (tick) nxt = ST_HIGH;
            ST_GAP:   if (tick && gap_hold_q) nxt = enable ? ST_SETUP : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        sclk  = 1'b0;
        sel_n = 1'b1;
        busy  = 1'b1;
        unique case (state)
            ST_IDLE:  busy  = 1'b0;
            ST_SETUP: sel_n = 1'b0;
            ST_HIGH:  begin sel_n = 1'b0; sclk = 1'b1; end
            ST_LOW:   sel_n = 1'b0;
            ST_GAP:   sel_n = 1'b1;
            default:  busy  = 1'b0;
        endcase
    end

    // frame datapath: channel pointer, bit counter, shifter, latched settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q       <= '0;
            bits_q     <= '0;
            shreg_q    <= '0;
            gap_hold_q <= 1'b0;
            mode_q     <= MD_QUAD12;
            half_q     <= '0;
        end else begin
            if (state == ST_IDLE && enable) begin
                mode_q <= mode_in;
                half_q <= half_live;
                ch_q   <= '0;
            end
            if (nxt == ST_SETUP && state != ST_SETUP) begin
                bits_q  <= '0;
                shreg_q <= '0;
            end
            if (nxt == ST_HIGH && state != ST_HIGH) begin
                bits_q  <= bits_q + 1'b1;
                shreg_q <= {shreg_q[SW-2:0], miso};
            end
            if (state == ST_HIGH && nxt == ST_GAP) begin
                gap_hold_q <= 1'b0;
            end else if (state == ST_GAP && tick) begin
                gap_hold_q <= 1'b1;
            end
            if (state == ST_GAP && nxt == ST_SETUP) begin
                ch_q <= (ch_q == last_ch) ? '0 : ch_q + 1'b1;
            end
        end
    end

    assign half_m1 = (state == ST_IDLE) ? half_live : half_q;
    assign cs_code = (mode_q == MD_QUAD12) ? CHW'(ch_q[1:0]) : ch_q;
    assign wr_en   = (state == ST_HIGH) && tick && last_bit;
    assign wr_ch   = ch_q;
    assign wr_data = shreg_q;

endmodule

// File: rtl/rr_adc_result_bank.sv
module rr_adc_result_bank #(
    parameter int NCH = 8,
    parameter int SW  = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(NCH)-1:0] wr_ch,
    input  logic [SW-1:0]          wr_data,
    input  logic [$clog2(NCH)-1:0] rd_sel,
    output logic [SW-1:0]          rd_data,
    output logic [NCH-1:0]         valid_vec
);

    logic [SW-1:0] data_q [NCH];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[g]    <= '0;
                valid_vec[g] <= 1'b0;
            end else if (wr_en && wr_ch == g) begin
                data_q[g]    <= wr_data;
                valid_vec[g] <= 1'b1;
            end
        end
    end

    assign rd_data = data_q[rd_sel];

endmodule

// File: rtl/rr_adc_sampler.sv
module rr_adc_sampler #(
    parameter int NCH   = 8,
    parameter int SW    = 16,
    parameter int DIV_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic [1:0]             mode,
    input  logic [DIV_W-1:0]       sclk_half,
    input  logic                   miso,
    output logic                   sclk,
    output logic                   sel_n,
    output logic [$clog2(NCH)-1:0] cs_code,
    input  logic [$clog2(NCH)-1:0] rd_sel,
    output logic [SW-1:0]          rd_data,
    output logic [NCH-1:0]         valid_vec
);

    localparam int CHW = $clog2(NCH);

    logic             busy;
    logic             tick;
    logic [DIV_W-1:0] half_m1;
    logic [DIV_W-1:0] cur_half_m1;
    logic [1:0]       cur_mode;
    logic             wr_en;
    logic [CHW-1:0]   wr_ch;
    logic [SW-1:0]    wr_data;

    rr_adc_sclk_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (busy),
        .half_m1 (half_m1),
        .tick    (tick)
    );

    rr_adc_frame_ctrl #(.NCH(NCH), .SW(SW), .DIV_W(DIV_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode_in (mode),
        .half_in (sclk_half),
        .tick    (tick),
        .miso    (miso),
        .busy    (busy),
        .half_m1 (half_m1),
        .sclk    (sclk),
        .sel_n   (sel_n),
        .cs_code (cs_code),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_data (wr_data),
        .mode_q  (cur_mode),
        .half_q  (cur_half_m1)
    );

    rr_adc_result_bank #(.NCH(NCH), .SW(SW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .valid_vec (valid_vec)
    );

endmodule

// File: rtl/rr_adc_checker.sv
module rr_adc_checker
    import rr_adc_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int DIV_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   sclk,
    input logic                   sel_n,
    input logic [$clog2(NCH)-1:0] cs_code,
    input logic [NCH-1:0]         valid_vec,
    input logic                   busy,
    input logic [1:0]             cur_mode,
    input logic [DIV_W-1:0]       cur_half_m1
);

    localparam int CHW = $clog2(NCH);
    localparam int GW  = DIV_W + 2;

    logic [GW-1:0] gap_cnt;
    logic [GW-1:0] gap_need;
    logic [5:0]    rise_cnt;
    logic          sclk_d, sel_d, seen;

    assign gap_need = ({2'b00, cur_half_m1} + GW'(1)) << 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt  <= '0;
            rise_cnt <= '0;
            sclk_d   <= 1'b0;
            sel_d    <= 1'b1;
            seen     <= 1'b0;
        end else begin
            sclk_d <= sclk;
            sel_d  <= sel_n;
            if (!sel_n) gap_cnt <= '0;
            else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
            if (sel_n) rise_cnt <= '0;
            else if (sclk && !sclk_d) rise_cnt <= rise_cnt + 1'b1;
            if (!busy) seen <= 1'b0;
            else if (sel_n && !sel_d) seen <= 1'b1;
        end
    end

    AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sel_n); // R11

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && $past(!sel_n)) |-> $stable(cs_code)); // R7

    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sel_n) && seen) |-> (gap_cnt >= gap_need)); // R7

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_n) |-> (rise_cnt == 6'(mode_width(cur_mode)))); // R4

    AST_QUAD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && cur_mode == MD_QUAD12) |-> (cs_code[CHW-1:2] == '0)); // R8

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((valid_vec & $past(valid_vec)) == $past(valid_vec))); // R9

endmodule

bind rr_adc_sampler rr_adc_checker #(.NCH(NCH), .DIV_W(DIV_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sclk        (sclk),
    .sel_n       (sel_n),
    .cs_code     (cs_code),
    .valid_vec   (valid_vec),
    .busy        (busy),
    .cur_mode    (cur_mode),
    .cur_half_m1 (cur_half_m1)
);

// File: tb/sim_rr_adc_sampler.sv
`timescale 1ns/1ps
module sim_rr_adc_sampler;

    localparam int NCH   = 8;
    localparam int SW    = 16;
    localparam int DIV_W = 8;
    localparam int CHW   = $clog2(NCH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b0;
    logic [1:0]       mode = 2'b00;
    logic [DIV_W-1:0] sclk_half = 8'd1;
    logic             miso = 1'b0;
    logic             sclk, sel_n;
    logic [CHW-1:0]   cs_code;
    logic [CHW-1:0]   rd_sel = '0;
    logic [SW-1:0]    rd_data;
    logic [NCH-1:0]   valid_vec;

    always #2 clk = ~clk;

    rr_adc_sampler #(.NCH(NCH), .SW(SW), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
        .sclk_half(sclk_half), .miso(miso), .sclk(sclk), .sel_n(sel_n),
        .cs_code(cs_code), .rd_sel(rd_sel), .rd_data(rd_data), .valid_vec(valid_vec)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int s_width(input int m);
        return (m == 0) ? 12 : (m == 1) ? 15 : 16;
    endfunction

    function automatic int s_chans(input int m);
        return (m == 0) ? 4 : 8;
    endfunction

    function automatic int adc_val(input int seed, input int ch, input int w);
        return (seed * 40503 + ch * 9973 + ch * ch * 271 + 5) & ((1 << w) - 1);
    endfunction

    // scenario settings seen by the converter model and monitor
    int s_mode = 0, s_half = 1, s_seed = 0;
    int exp_ch = 0, frames = 0, frames_total = 0;
    int rises = 0, hi_len = 0, lo_len = 0, gap_len = 0, bitidx = 0;
    int cur_val = 0, cur_w = 12;
    int exp_data [NCH];
    bit exp_valid [NCH];

    // converter model and frame monitor, sampled away from the clock edge
    initial begin
        logic p_sel, p_sclk;
        p_sel = 1'b1;
        p_sclk = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (sclk && sel_n) chk(0, "R11", "sclk high while deselected", 1, 0);
                if (!sel_n && p_sel) begin
                    int code_exp;
                    code_exp = exp_ch;
                    chk(cs_code == CHW'(code_exp), (s_mode == 0) ? "R8" : "R3",
                        "channel code at frame start", cs_code, code_exp);
                    if (frames > 0)
                        chk(gap_len == 2 * s_half, "R7", "deselect gap", gap_len, 2 * s_half);
                    exp_ch = (exp_ch + 1) % s_chans(s_mode);
                    cur_w = s_width(s_mode);
                    cur_val = adc_val(s_seed, int'(cs_code), cur_w);
                    miso = cur_val[cur_w-1];
                    bitidx = cur_w - 2;
                    rises = 0;
                    lo_len = 1;
                end else if (!sel_n && sclk && !p_sclk) begin
                    chk(lo_len == s_half, "R6", "low phase length", lo_len, s_half);
                    rises++;
                    hi_len = 1;
                end else if (!sel_n && sclk) begin
                    hi_len++;
                end else if (!sel_n && !sclk && p_sclk) begin
                    chk(hi_len == s_half, "R6", "high phase length", hi_len, s_half);
                    if (bitidx >= 0) miso = cur_val[bitidx];
                    bitidx--;
                    lo_len = 1;
                end else if (!sel_n) begin
                    lo_len++;
                end
                if (sel_n && !p_sel) begin
                    if (p_sclk) chk(hi_len == s_half, "R6", "last high phase", hi_len, s_half);
                    chk(rises == cur_w, "R4", "rising edges per frame", rises, cur_w);
                    frames++;
                    frames_total++;
                    gap_len = 1;
                end else if (sel_n) begin
                    gap_len++;
                end
                p_sel = sel_n;
                p_sclk = sclk;
            end
        end
    end

    task automatic run_scn(input int m, input int h, input int seed, input bit change_mid);
        int nch, f0;
        @(negedge clk);
        s_mode = m;
        s_half = (h == 0) ? 1 : h;
        s_seed = seed;
        exp_ch = 0;
        frames = 0;
        mode = 2'(m);
        sclk_half = DIV_W'(h);
        enable = 1'b1;
        nch = s_chans(m);
        while (frames < 2 * nch + 1) begin
            @(posedge clk);
            if (change_mid && frames == 3) begin
                mode = 2'b10;      // R10: must not take effect while running
                sclk_half = 8'd5;
            end
        end
        @(negedge clk);
        enable = 1'b0;
        repeat (40 * s_half + 20) @(posedge clk);
        f0 = frames;
        chk(sel_n == 1'b1, "R10", "deselected after stop", sel_n, 1);
        repeat (300) @(posedge clk);
        chk(frames == f0, "R10", "no frame after stop", frames, f0);
        for (int c = 0; c < nch; c++) begin
            exp_data[c] = adc_val(seed, c, s_width(m));
            exp_valid[c] = 1'b1;
        end
        for (int c = 0; c < NCH; c++) begin
            @(negedge clk);
            rd_sel = CHW'(c);
            #1;
            chk(rd_data == SW'(exp_data[c]), "R5", $sformatf("result ch%0d mode%0d", c, m),
                rd_data, exp_data[c]);
            chk(valid_vec[c] == exp_valid[c], "R9", $sformatf("valid ch%0d", c),
                valid_vec[c], exp_valid[c]);
        end
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) begin
            exp_data[c] = 0;
            exp_valid[c] = 1'b0;
        end
        repeat (5) @(posedge clk);
        #1;
        chk(sel_n == 1'b1, "R1", "sel_n in reset", sel_n, 1);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(valid_vec == '0, "R1", "valid in reset", valid_vec, 0);
        chk(rd_data == '0, "R1", "result in reset", rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (60) @(posedge clk);
        #1;
        chk(frames_total == 0, "R2", "frames while disabled", frames_total, 0);
        chk(sel_n == 1'b1 && sclk == 1'b0, "R2", "idle lines while disabled", {sel_n, sclk}, 2);
        run_scn(0, 1, 1, 1'b1);
        run_scn(1, 2, 2, 1'b0);
        run_scn(2, 1, 3, 1'b0);
        run_scn(3, 3, 4, 1'b0);
        run_scn(0, 0, 5, 1'b0);
        run_scn(2, 4, 6, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule